// File: doc/BRIEF.md
# LL/SC Reservation Tracker

This block keeps the single load-linked / store-conditional reservation of a processor data port. An LL issue stores the reserved physical address and cancels whatever reservation was already held. The first response flit of that LL brings back a key from the memory side. The same event loads a lifetime counter with a fixed timeout. While the counter is non-zero the reservation is live, and it counts down by one every cycle. It therefore dies on its own after a bounded number of cycles, unless something kills it first.

Three kinds of event kill the reservation early: a local write to the reserved address, a compare-and-swap to it (such as a page-table bit update), and an explicit clear command. When the processor presents an SC, the block decides locally whether it can succeed. If it can, the block emits a two-flit SC command: the stored key first, then the store data. If not, it reports failure at once and sends no memory traffic. LL and SC targets are always treated as non-cacheable by the surrounding data path; the cache arrays, TLB and interconnect are outside this block.

Top module: `llsc_resv_tracker`

## Requirements
- R1: After reset the reservation is invalid (`resv_valid_o` = 0), and `resv_valid_o` is 1 exactly when the lifetime counter is non-zero.
- R2: An LL issue loads the reserved address at the clock edge and cancels any live reservation, so `resv_valid_o` is 0 in the next cycle.
- R3: A first LL response flit loads `key_o` with its data and loads the counter with TIMEOUT, so `resv_valid_o` is 1 in the next cycle.
- R4: Counter priority is load over clear over decrement: an LL response in the same cycle as a matching write leaves the reservation live, with the counter at TIMEOUT.
- R5: With no load or clear, a live counter decrements once per cycle, so a reservation stays valid for exactly TIMEOUT cycles after it is loaded.
- R6: A local write whose address equals the reserved address clears the reservation. A write to any other address leaves the reservation unchanged.
- R7: A CAS notification whose address equals the reserved address clears the reservation.
- R8: The explicit clear command clears the reservation.
- R9: An SC request whose address equals the reserved address while the reservation is valid succeeds. In the next cycle `sc_rsp_valid_o` = 1 with word 0, and `sc_cmd_valid_o` = 1.
- R10: Any other SC request fails. In the next cycle `sc_rsp_valid_o` = 1 with word 1, and `sc_cmd_valid_o` = 0.
- R11: The SC command carries the key in flit 0 and the store data in flit 1. All four byte enables are set (4'hF), and the address is the SC address with bits [1:0] cleared.
- R12: One SC request gives exactly one cycle of `sc_rsp_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ll_issue_i | input | 1 | LL issued this cycle |
| ll_addr_i | input | PA_W | LL physical address |
| ll_rsp_first_i | input | 1 | First LL response flit valid |
| ll_rsp_data_i | input | DW | First LL response flit data (key) |
| wr_notify_i | input | 1 | Local write performed |
| wr_addr_i | input | PA_W | Local write physical address |
| cas_notify_i | input | 1 | CAS issued |
| cas_addr_i | input | PA_W | CAS physical address |
| sw_clear_i | input | 1 | Explicit reservation clear |
| sc_req_i | input | 1 | SC request |
| sc_addr_i | input | PA_W | SC physical address |
| sc_data_i | input | DW | SC store data |
| resv_valid_o | output | 1 | Reservation live |
| key_o | output | DW | Stored key |
| sc_rsp_valid_o | output | 1 | SC local result pulse |
| sc_rsp_word_o | output | DW | 0 = forwarded, 1 = failed |
| sc_cmd_valid_o | output | 1 | SC command pulse |
| sc_cmd_addr_o | output | PA_W | SC command address, word aligned |
| sc_cmd_flit0_o | output | DW | First data flit (key) |
| sc_cmd_flit1_o | output | DW | Second data flit (store data) |
| sc_cmd_be_o | output | DW/8 | Byte enables |

## Verification
The bench targets the last live cycle of a reservation. If the decrement were off by one, the reservation would outlive TIMEOUT or die a cycle early, and an SC on that edge would get the wrong verdict. It also drives an LL response and a matching write in the same cycle; a design with the priority inverted would drop the fresh reservation. It checks that an address comparison uses the held reserved address: a non-matching write must not clear it, and an LL issue to a new address must cancel the old one at once. Finally, it checks that a failed SC never raises the command strobe and that the key, not the store data, leads the command.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  typedef enum logic [1:0] {
    CNT_HOLD  = 2'd0,
    CNT_LOAD  = 2'd1,
    CNT_CLEAR = 2'd2,
    CNT_DEC   = 2'd3
  } cnt_op_e;

  localparam logic [31:0] SC_WORD_OK   = 32'd0;
  localparam logic [31:0] SC_WORD_FAIL = 32'd1;

endpackage

// File: rtl/llsc_life_counter.sv
module llsc_life_counter
  import llsc_pkg::*;
#(
  parameter int TIMEOUT = 1024,
  parameter int CNT_W   = $clog2(TIMEOUT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic clear_i,
  output logic live_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  cnt_op_e          op;

  // Priority: load, then clear, then decrement
  always_comb begin
    if (load_i)             op = CNT_LOAD;
    else if (clear_i)       op = CNT_CLEAR;
    else if (cnt_q != '0)   op = CNT_DEC;
    else                    op = CNT_HOLD;
  end

  always_comb begin
    cnt_en = (op != CNT_HOLD);
    unique case (op)
      CNT_LOAD:  cnt_d = CNT_W'(TIMEOUT);
      CNT_CLEAR: cnt_d = '0;
      CNT_DEC:   cnt_d = cnt_q - 1'b1;
      default:   cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign live_o = (cnt_q != '0);

  assert_load_timeout_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == CNT_W'(TIMEOUT)));

  assert_clear_beats_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && !load_i) |=> !live_o);

  assert_step_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !clear_i && live_o) |=> (cnt_q == $past(cnt_q) - 1'b1));

  assert_dead_stays_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !live_o) |=> !live_o);

endmodule

// File: rtl/llsc_resv_regs.sv
module llsc_resv_regs #(
  parameter int PA_W = 40,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            addr_ld_i,
  input  logic [PA_W-1:0] addr_i,
  input  logic            key_ld_i,
  input  logic [DW-1:0]   key_i,
  output logic [PA_W-1:0] addr_o,
  output logic [DW-1:0]   key_o
);

  logic [PA_W-1:0] addr_q;
  logic [DW-1:0]   key_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         addr_q <= '0;
    else if (addr_ld_i) addr_q <= addr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        key_q <= '0;
    else if (key_ld_i) key_q <= key_i;
  end

  assign addr_o = addr_q;
  assign key_o  = key_q;

  assert_addr_loaded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ld_i |=> (addr_o == $past(addr_i)));

  assert_key_loaded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    key_ld_i |=> (key_o == $past(key_i)));

endmodule

// File: rtl/llsc_sc_judge.sv
module llsc_sc_judge
  import llsc_pkg::*;
#(
  parameter int PA_W = 40,
  parameter int DW   = 32,
  localparam int BE_W = DW / 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sc_req_i,
  input  logic [PA_W-1:0] sc_addr_i,
  input  logic [DW-1:0]   sc_data_i,
  input  logic            live_i,
  input  logic [PA_W-1:0] resv_addr_i,
  input  logic [DW-1:0]   key_i,
  output logic            rsp_valid_o,
  output logic [DW-1:0]   rsp_word_o,
  output logic            cmd_valid_o,
  output logic [PA_W-1:0] cmd_addr_o,
  output logic [DW-1:0]   cmd_flit0_o,
  output logic [DW-1:0]   cmd_flit1_o,
  output logic [BE_W-1:0] cmd_be_o
);

  logic            win;
  logic            rsp_valid_q, cmd_valid_q;
  logic [DW-1:0]   rsp_word_q, rsp_word_d;
  logic [PA_W-1:0] cmd_addr_q, cmd_addr_d;
  logic [DW-1:0]   flit0_q, flit1_q;

  always_comb begin
    win        = sc_req_i && live_i && (sc_addr_i == resv_addr_i);
    rsp_word_d = win ? DW'(SC_WORD_OK) : DW'(SC_WORD_FAIL);
    cmd_addr_d = {sc_addr_i[PA_W-1:2], 2'b00};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      cmd_valid_q <= 1'b0;
    end else begin
      rsp_valid_q <= sc_req_i;
      cmd_valid_q <= win;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rsp_word_q <= '0;
    else if (sc_req_i) rsp_word_q <= rsp_word_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_addr_q <= '0;
      flit0_q    <= '0;
      flit1_q    <= '0;
    end else if (win) begin
      cmd_addr_q <= cmd_addr_d;
      flit0_q    <= key_i;
      flit1_q    <= sc_data_i;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_word_o  = rsp_word_q;
  assign cmd_valid_o = cmd_valid_q;
  assign cmd_addr_o  = cmd_addr_q;
  assign cmd_flit0_o = flit0_q;
  assign cmd_flit1_o = flit1_q;
  assign cmd_be_o    = {BE_W{1'b1}};

  assert_hit_forwards_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_req_i && live_i && sc_addr_i == resv_addr_i) |=> (cmd_valid_o && rsp_word_o == '0));

  assert_fail_no_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && rsp_word_o != '0) |-> !cmd_valid_o);

  assert_cmd_shape_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> (cmd_addr_o[1:0] == 2'b00 && cmd_be_o == {BE_W{1'b1}}));

  assert_rsp_from_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> $past(sc_req_i));

endmodule

// File: rtl/llsc_resv_tracker.sv
module llsc_resv_tracker #(
  parameter int PA_W    = 40,
  parameter int DW      = 32,
  parameter int TIMEOUT = 1024,
  localparam int BE_W   = DW / 8,
  localparam int CNT_W  = $clog2(TIMEOUT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ll_issue_i,
  input  logic [PA_W-1:0] ll_addr_i,
  input  logic            ll_rsp_first_i,
  input  logic [DW-1:0]   ll_rsp_data_i,
  input  logic            wr_notify_i,
  input  logic [PA_W-1:0] wr_addr_i,
  input  logic            cas_notify_i,
  input  logic [PA_W-1:0] cas_addr_i,
  input  logic            sw_clear_i,
  input  logic            sc_req_i,
  input  logic [PA_W-1:0] sc_addr_i,
  input  logic [DW-1:0]   sc_data_i,
  output logic            resv_valid_o,
  output logic [DW-1:0]   key_o,
  output logic            sc_rsp_valid_o,
  output logic [DW-1:0]   sc_rsp_word_o,
  output logic            sc_cmd_valid_o,
  output logic [PA_W-1:0] sc_cmd_addr_o,
  output logic [DW-1:0]   sc_cmd_flit0_o,
  output logic [DW-1:0]   sc_cmd_flit1_o,
  output logic [BE_W-1:0] sc_cmd_be_o
);

  logic [PA_W-1:0] resv_addr;
  logic            live;
  logic            wr_hit, cas_hit, kill_req;

  always_comb begin
    wr_hit   = wr_notify_i  && (wr_addr_i  == resv_addr);
    cas_hit  = cas_notify_i && (cas_addr_i == resv_addr);
    kill_req = ll_issue_i || wr_hit || cas_hit || sw_clear_i;
  end

  llsc_life_counter #(.TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) u_life (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (ll_rsp_first_i),
    .clear_i (kill_req),
    .live_o  (live)
  );

  llsc_resv_regs #(.PA_W(PA_W), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_ld_i (ll_issue_i),
    .addr_i    (ll_addr_i),
    .key_ld_i  (ll_rsp_first_i),
    .key_i     (ll_rsp_data_i),
    .addr_o    (resv_addr),
    .key_o     (key_o)
  );

  llsc_sc_judge #(.PA_W(PA_W), .DW(DW)) u_judge (
    .clk         (clk),
    .rst_n       (rst_n),
    .sc_req_i    (sc_req_i),
    .sc_addr_i   (sc_addr_i),
    .sc_data_i   (sc_data_i),
    .live_i      (live),
    .resv_addr_i (resv_addr),
    .key_i       (key_o),
    .rsp_valid_o (sc_rsp_valid_o),
    .rsp_word_o  (sc_rsp_word_o),
    .cmd_valid_o (sc_cmd_valid_o),
    .cmd_addr_o  (sc_cmd_addr_o),
    .cmd_flit0_o (sc_cmd_flit0_o),
    .cmd_flit1_o (sc_cmd_flit1_o),
    .cmd_be_o    (sc_cmd_be_o)
  );

  assign resv_valid_o = live;

  assert_write_hit_kills_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_notify_i && wr_addr_i == resv_addr && !ll_rsp_first_i) |=> !resv_valid_o);

  assert_cas_hit_kills_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_notify_i && cas_addr_i == resv_addr && !ll_rsp_first_i) |=> !resv_valid_o);

  assert_sw_clear_kills_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clear_i && !ll_rsp_first_i) |=> !resv_valid_o);

  assert_ll_cancels_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ll_issue_i && !ll_rsp_first_i) |=> !resv_valid_o);

  assert_load_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ll_rsp_first_i |=> resv_valid_o);

endmodule

// File: tb/llsc_resv_tracker_tb.sv
module llsc_resv_tracker_tb_top;

  localparam int PA_W    = 40;
  localparam int DW      = 32;
  localparam int TIMEOUT = 1024;
  localparam int CLK_PERIOD = 10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            ll_issue_i = 0, ll_rsp_first_i = 0, wr_notify_i = 0;
  logic            cas_notify_i = 0, sw_clear_i = 0, sc_req_i = 0;
  logic [PA_W-1:0] ll_addr_i = '0, wr_addr_i = '0, cas_addr_i = '0, sc_addr_i = '0;
  logic [DW-1:0]   ll_rsp_data_i = '0, sc_data_i = '0;
  logic            resv_valid_o, sc_rsp_valid_o, sc_cmd_valid_o;
  logic [DW-1:0]   key_o, sc_rsp_word_o, sc_cmd_flit0_o, sc_cmd_flit1_o;
  logic [PA_W-1:0] sc_cmd_addr_o;
  logic [3:0]      sc_cmd_be_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  llsc_resv_tracker #(.PA_W(PA_W), .DW(DW), .TIMEOUT(TIMEOUT)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .ll_issue_i(ll_issue_i), .ll_addr_i(ll_addr_i),
    .ll_rsp_first_i(ll_rsp_first_i), .ll_rsp_data_i(ll_rsp_data_i),
    .wr_notify_i(wr_notify_i), .wr_addr_i(wr_addr_i),
    .cas_notify_i(cas_notify_i), .cas_addr_i(cas_addr_i),
    .sw_clear_i(sw_clear_i),
    .sc_req_i(sc_req_i), .sc_addr_i(sc_addr_i), .sc_data_i(sc_data_i),
    .resv_valid_o(resv_valid_o), .key_o(key_o),
    .sc_rsp_valid_o(sc_rsp_valid_o), .sc_rsp_word_o(sc_rsp_word_o),
    .sc_cmd_valid_o(sc_cmd_valid_o), .sc_cmd_addr_o(sc_cmd_addr_o),
    .sc_cmd_flit0_o(sc_cmd_flit0_o), .sc_cmd_flit1_o(sc_cmd_flit1_o),
    .sc_cmd_be_o(sc_cmd_be_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int              m_life;
  logic [PA_W-1:0] m_addr;
  logic [DW-1:0]   m_key;
  bit              m_rspv, m_cmdv;
  logic [DW-1:0]   m_word, m_f0, m_f1;
  logic [PA_W-1:0] m_caddr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_life = 0; m_addr = '0; m_key = '0; m_rspv = 0; m_cmdv = 0;
      m_word = '0; m_f0 = '0; m_f1 = '0; m_caddr = '0;
    end else begin
      bit ok, kill;
      ok = sc_req_i && (m_life > 0) && (sc_addr_i == m_addr);
      m_rspv = sc_req_i;
      m_cmdv = ok;
      if (sc_req_i) m_word = ok ? 32'd0 : 32'd1;
      if (ok) begin
        m_caddr = sc_addr_i & ~(PA_W'(3));
        m_f0 = m_key;
        m_f1 = sc_data_i;
      end
      kill = ll_issue_i || sw_clear_i ||
             (wr_notify_i && wr_addr_i == m_addr) ||
             (cas_notify_i && cas_addr_i == m_addr);
      if (ll_rsp_first_i)  begin m_life = TIMEOUT; m_key = ll_rsp_data_i; end
      else if (kill)       m_life = 0;
      else if (m_life > 0) m_life = m_life - 1;
      if (ll_issue_i) m_addr = ll_addr_i;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 valid", 64'(resv_valid_o), 64'(m_life > 0));
      chk("R3 key", 64'(key_o), 64'(m_key));
      chk("R12 rsp_valid", 64'(sc_rsp_valid_o), 64'(m_rspv));
      if (m_rspv) chk("R9/R10 rsp word", 64'(sc_rsp_word_o), 64'(m_word));
      chk("R10 cmd_valid", 64'(sc_cmd_valid_o), 64'(m_cmdv));
      if (m_cmdv) begin
        chk("R11 cmd addr", 64'(sc_cmd_addr_o), 64'(m_caddr));
        chk("R11 flit0", 64'(sc_cmd_flit0_o), 64'(m_f0));
        chk("R11 flit1", 64'(sc_cmd_flit1_o), 64'(m_f1));
        chk("R11 be", 64'(sc_cmd_be_o), 64'h0F);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    ll_issue_i = 0; ll_rsp_first_i = 0; wr_notify_i = 0;
    cas_notify_i = 0; sw_clear_i = 0; sc_req_i = 0;
  endtask

  task automatic do_ll(input logic [PA_W-1:0] a);
    ll_issue_i = 1; ll_addr_i = a; tick();
  endtask
  task automatic do_rsp(input logic [DW-1:0] k);
    ll_rsp_first_i = 1; ll_rsp_data_i = k; tick();
  endtask
  task automatic do_wr(input logic [PA_W-1:0] a);
    wr_notify_i = 1; wr_addr_i = a; tick();
  endtask
  task automatic do_sc(input logic [PA_W-1:0] a, input logic [DW-1:0] d);
    sc_req_i = 1; sc_addr_i = a; sc_data_i = d; tick();
  endtask
  task automatic reserve(input logic [PA_W-1:0] a, input logic [DW-1:0] k);
    do_ll(a); do_rsp(k);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  localparam logic [PA_W-1:0] A = 40'h12_3456_789B;
  localparam logic [PA_W-1:0] B = 40'h00_0000_4000;

  initial begin
    int live_cycles;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset valid", 64'(resv_valid_o), 64'd0);
    chk("R12 reset rsp", 64'(sc_rsp_valid_o), 64'd0);

    // R3: load key and reservation
    do_ll(A);
    chk("R2 ll issue alone leaves invalid", 64'(resv_valid_o), 64'd0);
    do_rsp(32'hCAFE_0001);
    chk("R3 valid after rsp", 64'(resv_valid_o), 64'd1);
    chk("R3 key captured", 64'(key_o), 64'hCAFE_0001);

    // R9/R11 success
    do_sc(A, 32'h5555_AAAA);
    chk("R9 success pulse", 64'(sc_rsp_valid_o), 64'd1);
    chk("R9 success word", 64'(sc_rsp_word_o), 64'd0);
    chk("R9 cmd valid", 64'(sc_cmd_valid_o), 64'd1);
    chk("R11 addr aligned", 64'(sc_cmd_addr_o), 64'h12_3456_7898);
    chk("R11 key first", 64'(sc_cmd_flit0_o), 64'hCAFE_0001);
    chk("R11 data second", 64'(sc_cmd_flit1_o), 64'h5555_AAAA);
    chk("R11 be", 64'(sc_cmd_be_o), 64'hF);
    tick();
    chk("R12 single pulse", 64'(sc_rsp_valid_o), 64'd0);

    // R10 fail on wrong address
    do_sc(B, 32'h1);
    chk("R10 fail word", 64'(sc_rsp_word_o), 64'd1);
    chk("R10 no cmd", 64'(sc_cmd_valid_o), 64'd0);

    // R6 writes
    do_wr(B);
    chk("R6 other write ignored", 64'(resv_valid_o), 64'd1);
    do_wr(A);
    chk("R6 matching write kills", 64'(resv_valid_o), 64'd0);
    do_sc(A, 32'h2);
    chk("R10 fail after kill", 64'(sc_rsp_word_o), 64'd1);

    // R7 CAS
    reserve(B, 32'h0000_BEEF);
    cas_notify_i = 1; cas_addr_i = A; tick();
    chk("R7 other cas ignored", 64'(resv_valid_o), 64'd1);
    cas_notify_i = 1; cas_addr_i = B; tick();
    chk("R7 cas kills", 64'(resv_valid_o), 64'd0);

    // R8 explicit clear
    reserve(A, 32'h1234_5678);
    sw_clear_i = 1; tick();
    chk("R8 clear kills", 64'(resv_valid_o), 64'd0);

    // R4 load beats clear
    do_ll(A);
    ll_rsp_first_i = 1; ll_rsp_data_i = 32'h0BAD_F00D;
    wr_notify_i = 1; wr_addr_i = A; tick();
    chk("R4 load wins", 64'(resv_valid_o), 64'd1);
    chk("R4 key", 64'(key_o), 64'h0BAD_F00D);

    // R2 new LL cancels old reservation
    do_ll(B);
    chk("R2 cancel", 64'(resv_valid_o), 64'd0);
    do_sc(A, 32'h3);
    chk("R2 old addr fails", 64'(sc_rsp_word_o), 64'd1);

    // R5 lifetime
    do_rsp(32'h7777_0000);
    live_cycles = 0;
    while (resv_valid_o && live_cycles < TIMEOUT + 10) begin
      live_cycles++;
      if (live_cycles == TIMEOUT) begin
        sc_req_i = 1; sc_addr_i = B; sc_data_i = 32'h9;
      end
      tick();
    end
    chk("R5 lifetime", 64'(live_cycles), 64'(TIMEOUT));
    chk("R9 last live cycle SC wins", 64'(sc_rsp_word_o), 64'd0);
    do_sc(B, 32'hA);
    chk("R10 expired SC fails", 64'(sc_rsp_word_o), 64'd1);

    repeat (3) tick();
    finish_run();
  end

endmodule